// File: doc/BRIEF.md
# Cell-Granular FIFO Handshake Bridge

This block sits between two cell-interface masters that share one clock. The upstream master pushes cell words into a buffer and the downstream master pulls them out. Because both sides drive their own enables, neither can wait on the other. The buffer works this out through two flags. A space flag tells the writer it may start sending. A cell flag tells the reader that enough words are stored for it to start reading. Both enables are active low. Each stored entry holds one data word, a parity bit and a start-of-cell marker, and all three come out together at the read side.

In cell mode, each flag is set by a threshold on a port, so one flag can allow a whole cell burst. The writer threshold is the occupancy at which the buffer counts as almost full. The reader threshold is the occupancy at which a cell counts as present. For a 27-word cell in a 64-entry buffer the values are 38 and 27. Cells longer than 27 words only need other threshold values. In word mode the writer only needs one free entry, so it sends one word for each cycle in which the space flag is high. A buffer that holds two cells lets a steady cell stream keep the space flag high for the whole run, provided the reader takes each cell as soon as it is flagged.

Top module: `cellfifo_bridge`

## Requirements
- R1: A synchronous active-high `rst` empties the buffer. It also clears `space_ok`, `cell_ok`, `ovf_err`, `unf_err` and the read outputs to 0 at the clock edge where it is sampled.
- R2: A write with `wr_en_n`=0 is accepted when the buffer is not full. Words come out in the order they were written, each with its own `wr_sof` and `wr_par`.
- R3: The read outputs are registered. A read accepted at an edge (`rd_en_n`=0, buffer not empty) presents its word right after that edge. The outputs hold their value across any edge with no accepted read.
- R4: In cell mode (`word_mode`=0), `space_ok` is 1 exactly when the occupancy after the latest edge is below `afull_lvl`. A level of 38 with depth 64 leaves at least 27 free entries.
- R5: `cell_ok` is 1 exactly when the occupancy after the latest edge is at least `aempty_lvl`. This holds in both modes and for any cell length, such as 27 or 30 words.
- R6: In word mode (`word_mode`=1), `space_ok` is 1 exactly when the occupancy after the latest edge is below the depth. `afull_lvl` has no effect in this mode.
- R7: Both flags are registered. They are computed from the threshold and mode inputs present at the same edge that sets the new occupancy.
- R8: A write to a full buffer and a read from an empty buffer change nothing stored. They set the sticky `ovf_err` or `unf_err`, which stays set until reset.
- R9: A write and a read in the same cycle are both accepted when the buffer is neither full nor empty, and the occupancy does not change. When full, only the read is accepted (`ovf_err` set). When empty, only the write is accepted (`unf_err` set).
- R10: With the defaults (depth 64, levels 38 and 27), consider a writer that sends 27-word cells whenever `space_ok` is 1 and a reader that takes 27 words whenever `cell_ok` is 1. The writer then never finds `space_ok` at 0 when it starts a cell.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst | input | 1 | Synchronous reset, active high |
| word_mode | input | 1 | 0 = cell handshake, 1 = word handshake |
| afull_lvl | input | CW | Occupancy at which the writer side counts as almost full |
| aempty_lvl | input | CW | Occupancy at which a cell counts as present for the reader |
| wr_en_n | input | 1 | Write enable, active low |
| wr_data | input | DATA_W | Word to store |
| wr_sof | input | 1 | Start-of-cell marker stored with the word |
| wr_par | input | 1 | Parity bit stored with the word |
| space_ok | output | 1 | Writer may send |
| rd_en_n | input | 1 | Read enable, active low |
| rd_data | output | DATA_W | Registered read word |
| rd_sof | output | 1 | Start-of-cell marker of the read word |
| rd_par | output | 1 | Parity bit of the read word |
| cell_ok | output | 1 | Reader may start a cell |
| ovf_err | output | 1 | Sticky: a write was dropped because the buffer was full |
| unf_err | output | 1 | Sticky: a read was dropped because the buffer was empty |

## Verification
Push and pop can happen in the same cycle. The bench drives both enables together at a partly filled level, at a full buffer and at an empty buffer. At the partly filled level it checks that the cell flag stays steady and that no error bit rises. At the full buffer it checks that only the pop goes through: the word-mode space flag comes back and the overflow bit rises. At the empty buffer it checks that the underflow bit rises and that the written word comes out later. A reference queue in the bench judges every cycle. It tracks occupancy, data order, both flags and both error bits, using the rule that acceptance depends on the occupancy before the edge.

// File: rtl/cfb_pkg.sv
package cfb_pkg;

    typedef enum logic {
        HS_CELL = 1'b0,
        HS_WORD = 1'b1
    } hs_mode_e;

    // side bits stored next to each data word
    typedef struct packed {
        logic sof;
        logic par;
    } word_tag_t;

    function automatic int unsigned addr_bits(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/cfb_ctrl.sv
module cfb_ctrl #(
    parameter int DEPTH = 64,
    parameter int AW    = 6,
    parameter int CW    = 7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_req,
    input  logic          rd_req,
    output logic          wr_go,
    output logic          rd_go,
    output logic [AW-1:0] wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [CW-1:0] count,
    output logic [CW-1:0] count_nxt,
    output logic          ovf,
    output logic          unf
);
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
    localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

    // acceptance is judged on the occupancy before the edge
    assign wr_go     = wr_req && (count != FULL_CNT);
    assign rd_go     = rd_req && (count != '0);
    assign count_nxt = count + CW'(wr_go) - CW'(rd_go);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
            ovf    <= 1'b0;
            unf    <= 1'b0;
        end else begin
            if (wr_go) wr_ptr <= (wr_ptr == LAST_PTR) ? '0 : wr_ptr + 1'b1;
            if (rd_go) rd_ptr <= (rd_ptr == LAST_PTR) ? '0 : rd_ptr + 1'b1;
            count <= count_nxt;
            ovf   <= ovf | (wr_req && !wr_go);
            unf   <= unf | (rd_req && !rd_go);
        end
    end

    assert_occupancy_limit_R2: assert property (@(posedge clk) disable iff (rst)
        count <= FULL_CNT);

    assert_full_write_dropped_R8: assert property (@(posedge clk) disable iff (rst)
        (wr_req && !rd_req && count == FULL_CNT) |=> (count == FULL_CNT && ovf));

    assert_empty_read_dropped_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !wr_req && count == '0) |=> (count == '0 && unf));

    assert_errors_sticky_R8: assert property (@(posedge clk) disable iff (rst)
        (ovf || unf) |=> ((ovf || !$past(ovf)) && (unf || !$past(unf))));

    assert_both_keep_count_R9: assert property (@(posedge clk) disable iff (rst)
        (wr_req && rd_req && count != '0 && count != FULL_CNT) |=> $stable(count));

endmodule

// File: rtl/cfb_store.sv
module cfb_store #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64,
    parameter int AW     = 6
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        wr_go,
    input  logic [AW-1:0]               wr_ptr,
    input  cfb_pkg::word_tag_t          wr_tag,
    input  logic [DATA_W-1:0]           wr_data,
    input  logic                        rd_go,
    input  logic [AW-1:0]               rd_ptr,
    output cfb_pkg::word_tag_t          rd_tag,
    output logic [DATA_W-1:0]           rd_data
);
    typedef struct packed {
        cfb_pkg::word_tag_t tag;
        logic [DATA_W-1:0]  data;
    } entry_t;

    entry_t mem [DEPTH];
    entry_t out_q;

    always_ff @(posedge clk) begin
        if (wr_go) mem[wr_ptr] <= '{tag: wr_tag, data: wr_data};
    end

    always_ff @(posedge clk) begin
        if (rst)        out_q <= '0;
        else if (rd_go) out_q <= mem[rd_ptr];
    end

    assign rd_tag  = out_q.tag;
    assign rd_data = out_q.data;

    assert_output_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !rd_go |=> $stable(out_q));

endmodule

// File: rtl/cfb_flags.sv
module cfb_flags #(
    parameter int DEPTH = 64,
    parameter int CW    = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  cfb_pkg::hs_mode_e mode,
    input  logic [CW-1:0]     afull_lvl,
    input  logic [CW-1:0]     aempty_lvl,
    input  logic [CW-1:0]     count_nxt,
    output logic              space_ok,
    output logic              cell_ok
);
    import cfb_pkg::*;
    localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);

    logic space_d;

    always_comb begin
        unique case (mode)
            HS_WORD: space_d = count_nxt < FULL_CNT;
            default: space_d = count_nxt < afull_lvl;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            space_ok <= 1'b0;
            cell_ok  <= 1'b0;
        end else begin
            space_ok <= space_d;
            cell_ok  <= count_nxt >= aempty_lvl;
        end
    end

    assert_flags_clear_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!space_ok && !cell_ok));

    assert_word_full_blocks_R6: assert property (@(posedge clk) disable iff (rst)
        (mode == HS_WORD && count_nxt == FULL_CNT) |=> !space_ok);

endmodule

// File: rtl/cellfifo_bridge.sv
module cellfifo_bridge #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 64,
    parameter int CW     = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              word_mode,
    input  logic [CW-1:0]     afull_lvl,
    input  logic [CW-1:0]     aempty_lvl,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_sof,
    input  logic              wr_par,
    output logic              space_ok,
    input  logic              rd_en_n,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_sof,
    output logic              rd_par,
    output logic              cell_ok,
    output logic              ovf_err,
    output logic              unf_err
);
    import cfb_pkg::*;
    localparam int AW = addr_bits(DEPTH);

    logic          wr_go, rd_go;
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count, count_nxt;
    word_tag_t     in_tag, out_tag;
    hs_mode_e      mode;

    assign in_tag = '{sof: wr_sof, par: wr_par};
    assign mode   = hs_mode_e'(word_mode);
    assign rd_sof = out_tag.sof;
    assign rd_par = out_tag.par;

    cfb_ctrl #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_ctrl (
        .clk(clk), .rst(rst),
        .wr_req(!wr_en_n), .rd_req(!rd_en_n),
        .wr_go(wr_go), .rd_go(rd_go),
        .wr_ptr(wr_ptr), .rd_ptr(rd_ptr),
        .count(count), .count_nxt(count_nxt),
        .ovf(ovf_err), .unf(unf_err)
    );

    cfb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk(clk), .rst(rst),
        .wr_go(wr_go), .wr_ptr(wr_ptr), .wr_tag(in_tag), .wr_data(wr_data),
        .rd_go(rd_go), .rd_ptr(rd_ptr), .rd_tag(out_tag), .rd_data(rd_data)
    );

    cfb_flags #(.DEPTH(DEPTH), .CW(CW)) u_flags (
        .clk(clk), .rst(rst), .mode(mode),
        .afull_lvl(afull_lvl), .aempty_lvl(aempty_lvl),
        .count_nxt(count_nxt),
        .space_ok(space_ok), .cell_ok(cell_ok)
    );

    assert_cell_flag_needs_words_R5: assert property (@(posedge clk) disable iff (rst)
        (cell_ok && $stable(aempty_lvl)) |-> (count >= aempty_lvl));

endmodule

// File: tb/cellfifo_bridge_test.sv
module cellfifo_bridge_test;
    localparam int DATA_W = 16;
    localparam int DEPTH  = 64;
    localparam int CW     = $clog2(DEPTH + 1);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic word_mode = 1'b0;
    logic [CW-1:0] afull_lvl = CW'(38);
    logic [CW-1:0] aempty_lvl = CW'(27);
    logic wr_en_n = 1'b1, rd_en_n = 1'b1;
    logic [DATA_W-1:0] wr_data = '0;
    logic wr_sof = 1'b0, wr_par = 1'b0;
    logic space_ok, cell_ok, ovf_err, unf_err, rd_sof, rd_par;
    logic [DATA_W-1:0] rd_data;

    always #2 clk = ~clk;

    cellfifo_bridge #(.DATA_W(DATA_W), .DEPTH(DEPTH)) uut (
        .clk(clk), .rst(rst), .word_mode(word_mode),
        .afull_lvl(afull_lvl), .aempty_lvl(aempty_lvl),
        .wr_en_n(wr_en_n), .wr_data(wr_data), .wr_sof(wr_sof), .wr_par(wr_par),
        .space_ok(space_ok), .rd_en_n(rd_en_n), .rd_data(rd_data),
        .rd_sof(rd_sof), .rd_par(rd_par), .cell_ok(cell_ok),
        .ovf_err(ovf_err), .unf_err(unf_err)
    );

    int nchk = 0;
    int nerr = 0;
    bit done = 0;
    logic [DATA_W-1:0] seq = 16'h1000;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // ---------------- scoreboard model ----------------
    logic [DATA_W+1:0] q[$];
    int m_cnt = 0;
    bit m_ovf = 0, m_unf = 0;
    logic [DATA_W+1:0] last_rd = '0;

    always begin
        bit s_rst, s_w, s_r, s_mode, wa, ra, sp_exp, ce_exp;
        logic [DATA_W+1:0] s_word;
        int s_af, s_ae;
        @(posedge clk);
        s_rst = rst; s_w = !wr_en_n; s_r = !rd_en_n; s_mode = word_mode;
        s_word = {wr_sof, wr_par, wr_data};
        s_af = int'(afull_lvl); s_ae = int'(aempty_lvl);
        #1;
        if (s_rst) begin
            q.delete(); m_cnt = 0; m_ovf = 0; m_unf = 0; last_rd = '0;
        end else begin
            wa = s_w && (m_cnt < DEPTH);
            ra = s_r && (m_cnt > 0);
            if (ra) last_rd = q.pop_front();
            if (wa) q.push_back(s_word);
            m_cnt = m_cnt + int'(wa) - int'(ra);
            if (s_w && !wa) m_ovf = 1;
            if (s_r && !ra) m_unf = 1;
            chk({rd_sof, rd_par, rd_data} == last_rd, ra ? "R2 read word" : "R3 hold",
                32'({rd_sof, rd_par, rd_data}), 32'(last_rd));
            sp_exp = s_mode ? (m_cnt < DEPTH) : (m_cnt < s_af);
            chk(space_ok == sp_exp, s_mode ? "R6 space_ok" : "R4 space_ok R7",
                32'(space_ok), 32'(sp_exp));
            ce_exp = (m_cnt >= s_ae);
            chk(cell_ok == ce_exp, "R5 cell_ok R7", 32'(cell_ok), 32'(ce_exp));
            chk(ovf_err == m_ovf, "R8 ovf_err", 32'(ovf_err), 32'(m_ovf));
            chk(unf_err == m_unf, "R8 unf_err", 32'(unf_err), 32'(m_unf));
        end
    end

    // ---------------- driver ----------------
    task automatic cyc(input bit w, input bit r, input bit sof);
        @(negedge clk);
        wr_en_n = !w; rd_en_n = !r;
        if (w) begin
            seq = seq + 1'b1;
            wr_data = seq; wr_sof = sof; wr_par = ^seq;
        end
    endtask

    task automatic idle();
        @(negedge clk);
        wr_en_n = 1'b1; rd_en_n = 1'b1;
    endtask

    task automatic after_edge();
        @(posedge clk); #1;
    endtask

    task automatic do_reset();
        @(negedge clk); rst = 1'b1; wr_en_n = 1'b1; rd_en_n = 1'b1;
        after_edge();
        chk(space_ok == 0 && cell_ok == 0, "R1 flags in reset", 32'({space_ok, cell_ok}), 0);
        chk(ovf_err == 0 && unf_err == 0, "R1 errors in reset", 32'({ovf_err, unf_err}), 0);
        chk(rd_data == 0 && rd_sof == 0 && rd_par == 0, "R1 read outputs in reset",
            32'(rd_data), 0);
        @(negedge clk); rst = 1'b0;
        after_edge();
        chk(space_ok == 1 && cell_ok == 0, "R1 empty after reset", 32'({space_ok, cell_ok}), 32'b10);
    endtask

    int lows = 0;

    initial begin
        repeat (3) @(posedge clk);
        do_reset();

        // one standard cell in and out, cell mode
        for (int k = 0; k < 27; k++) cyc(1, 0, k == 0);
        after_edge();
        chk(cell_ok == 1, "R5 full cell present", 32'(cell_ok), 1);
        for (int k = 0; k < 27; k++) cyc(0, 1, 0);
        after_edge();
        chk(rd_sof == 0 && cell_ok == 0, "R5 drained", 32'(cell_ok), 0);

        // fill past almost-full to full, then overflow
        for (int k = 0; k < 37; k++) cyc(1, 0, 0);
        after_edge();
        chk(space_ok == 1, "R4 occupancy 37 leaves space", 32'(space_ok), 1);
        cyc(1, 0, 0);
        after_edge();
        chk(space_ok == 0, "R4 occupancy 38 almost full", 32'(space_ok), 0);
        for (int k = 0; k < 26; k++) cyc(1, 0, 0);
        cyc(1, 0, 0);
        after_edge();
        chk(ovf_err == 1, "R8 write to full sets ovf", 32'(ovf_err), 1);
        word_mode = 1'b1;
        cyc(1, 1, 0);
        after_edge();
        chk(space_ok == 1, "R9 full: read taken write dropped", 32'(space_ok), 1);
        word_mode = 1'b0;
        for (int k = 0; k < 64; k++) cyc(0, 1, 0);
        after_edge();
        chk(unf_err == 1, "R8 read from empty sets unf", 32'(unf_err), 1);
        chk(ovf_err == 1, "R8 ovf stays set", 32'(ovf_err), 1);

        // word mode, almost-full level ignored
        do_reset();
        @(negedge clk); word_mode = 1'b1; afull_lvl = CW'(5);
        for (int k = 0; k < 63; k++) cyc(1, 0, 0);
        after_edge();
        chk(space_ok == 1, "R6 one entry free", 32'(space_ok), 1);
        cyc(1, 0, 0);
        after_edge();
        chk(space_ok == 0, "R6 full blocks writer", 32'(space_ok), 0);
        for (int k = 0; k < 64; k++) cyc(0, 1, 0);
        idle();

        // simultaneous push and pop
        do_reset();
        @(negedge clk); word_mode = 1'b0; afull_lvl = CW'(38);
        cyc(1, 1, 1);
        after_edge();
        chk(unf_err == 1 && cell_ok == 0, "R9 empty: write taken read dropped",
            32'({unf_err, cell_ok}), 32'b10);
        for (int k = 0; k < 26; k++) cyc(1, 0, 0);
        for (int k = 0; k < 10; k++) begin
            cyc(1, 1, 0);
            after_edge();
            chk(cell_ok == 1, "R9 occupancy steady", 32'(cell_ok), 1);
        end
        chk(ovf_err == 0, "R9 no overflow", 32'(ovf_err), 0);
        for (int k = 0; k < 27; k++) cyc(0, 1, 0);
        idle();

        // extended cell length of 30 words
        do_reset();
        @(negedge clk); aempty_lvl = CW'(30); afull_lvl = CW'(35);
        for (int k = 0; k < 29; k++) cyc(1, 0, k == 0);
        after_edge();
        chk(cell_ok == 0, "R5 29 of 30 words", 32'(cell_ok), 0);
        cyc(1, 0, 0);
        after_edge();
        chk(cell_ok == 1, "R5 30 of 30 words", 32'(cell_ok), 1);
        chk(space_ok == 1, "R4 extended level 35", 32'(space_ok), 1);
        for (int k = 0; k < 30; k++) cyc(0, 1, 0);
        idle();

        // continuous cell stream with default levels
        do_reset();
        @(negedge clk); aempty_lvl = CW'(27); afull_lvl = CW'(38);
        fork
            begin
                for (int c = 0; c < 12; c++) begin
                    @(negedge clk);
                    while (!space_ok) begin
                        lows++; wr_en_n = 1'b1; @(negedge clk);
                    end
                    for (int k = 0; k < 27; k++) begin
                        if (k != 0) @(negedge clk);
                        seq = seq + 1'b1;
                        wr_en_n = 1'b0; wr_data = seq; wr_sof = (k == 0); wr_par = ^seq;
                    end
                end
                @(negedge clk); wr_en_n = 1'b1;
            end
            begin
                for (int c = 0; c < 12; c++) begin
                    @(negedge clk);
                    while (!cell_ok) begin
                        rd_en_n = 1'b1; @(negedge clk);
                    end
                    for (int k = 0; k < 27; k++) begin
                        if (k != 0) @(negedge clk);
                        rd_en_n = 1'b0;
                    end
                end
                @(negedge clk); rd_en_n = 1'b1;
            end
        join
        chk(lows == 0, "R10 writer never stalled", 32'(lows), 0);
        after_edge();
        chk(cell_ok == 0 && space_ok == 1, "R10 stream drained", 32'({cell_ok, space_ok}), 32'b01);

        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            done = 1;
            nchk++; nerr++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

endmodule